// File: doc/BRIEF.md
# Edge-Timestamp Long Delay Line

This block delays a one-bit, pixel-clocked enable by a fixed number of clock cycles that may run to tens of thousands, for example a whole number of video lines plus a few pixels. The input changes level several times inside one delay window: high at line start, low at blanking, once each per line. A single reloading down-counter therefore cannot follow it. A one-stage-per-cycle shift register would cost one flip-flop per cycle of delay, so it is also ruled out.

The block instead keeps a free-running cycle stamp. Whenever the input changes level, it writes the stamp into a small queue. When the wrapped difference between the current stamp and the oldest queued stamp equals the delay, the output toggles and that entry leaves the queue. The output is the input waveform shifted by exactly the delay. Storage grows with the number of edges inside a window, not with the window's length.

The delay is set as `LINE_LEN * DELAY_LINES + DELAY_PIX`. The defaults give a 1346-cycle line and a 22-line, 11-pixel delay. An 11-line, 4-pixel delay is the other setting in use.

Top module: `edge_delay_line`

## Requirements
- R1: While reset is asserted, and immediately after it, `sig_o` is 0 and `ovf_o` is 0.
- R2: A rising edge of `sig_i` sampled at clock edge k appears on `sig_o` after clock edge k+DELAY, with DELAY = LINE_LEN*DELAY_LINES + DELAY_PIX.
- R3: A falling edge of `sig_i` is delayed by the same DELAY cycles as a rising edge.
- R4: An input that toggles many times inside one delay window is reproduced cycle-exact on `sig_o`, provided no more than DEPTH edges are pending at once.
- R5: A high pulse only one cycle wide is reproduced as a one-cycle pulse DELAY cycles later.
- R6: If an input edge arrives while DEPTH edges are already pending and none retires in that cycle, `ovf_o` goes to 1 after that clock edge. It stays 1 until reset.
- R7: Behaviour is unchanged when the internal cycle stamp wraps, so operation is correct indefinitely.
- R8: Reset discards all pending edges. After reset, with the input held low, `sig_o` stays 0 for the whole following delay window.
- R9: While no edges are pending, `sig_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sig_i | input | 1 | Enable to be delayed |
| sig_o | output | 1 | Enable delayed by DELAY cycles |
| ovf_o | output | 1 | Sticky flag: an input edge was dropped because the queue was full |

## Verification
Almost any fault in the stamp queue or stamp counter appears on `sig_o` exactly one delay window after the edge that met it, and not before. A lost or duplicated entry inverts the output from that point on. A wrong stamp shifts one transition by the error. A bad wrapped comparison makes an edge never retire or retire early once the stamp wraps. The bench therefore compares every cycle against an input history that is DELAY deep, runs well past a stamp wrap, and drives the queue exactly to its depth and one edge beyond.

// File: rtl/edly_pkg.sv
package edly_pkg;
  // smallest stamp width whose range exceeds the delay
  function automatic int stamp_width(int delay);
    return (delay < 1) ? 1 : $clog2(delay + 1);
  endfunction

  function automatic int ptr_width(int depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction
endpackage

// File: rtl/edly_edge_det.sv
module edly_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic edge_o
);
  logic sig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sig_q <= 1'b0;
    else         sig_q <= sig_i;
  end

  assign edge_o = sig_i ^ sig_q;
endmodule

// File: rtl/edly_stamp_ctr.sv
module edly_stamp_ctr #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  output logic [W-1:0] stamp_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stamp_o <= '0;
    else         stamp_o <= stamp_o + 1'b1;
  end
endmodule

// File: rtl/edly_stamp_fifo.sv
module edly_stamp_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 52,
  parameter int PW    = edly_pkg::ptr_width(DEPTH),
  parameter int LW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [W-1:0]  data_i,
  input  logic          pop_i,
  output logic [W-1:0]  head_o,
  output logic          empty_o,
  output logic          full_o,
  output logic [LW-1:0] level_o
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;

  // pointer wrap: free for power-of-two depth, compare otherwise
  generate
    if ((1 << PW) == DEPTH) begin : g_pow2
      assign wr_nxt = wr_ptr + 1'b1;
      assign rd_nxt = rd_ptr + 1'b1;
    end else begin : g_mod
      assign wr_nxt = (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      assign rd_nxt = (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
    end
  endgenerate

  assign empty_o = (level_o == '0);
  assign full_o  = (level_o == LW'(DEPTH));
  assign head_o  = mem[rd_ptr];

  always_ff @(posedge clk_i) begin
    if (push_i) mem[wr_ptr] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      level_o <= '0;
    end else begin
      if (push_i) wr_ptr <= wr_nxt;
      if (pop_i)  rd_ptr <= rd_nxt;
      case ({push_i, pop_i})
        2'b10:   level_o <= level_o + 1'b1;
        2'b01:   level_o <= level_o - 1'b1;
        default: level_o <= level_o;
      endcase
    end
  end
endmodule

// File: rtl/edge_delay_line.sv
module edge_delay_line #(
  parameter int LINE_LEN    = 1346,
  parameter int DELAY_LINES = 22,
  parameter int DELAY_PIX   = 11,
  parameter int DEPTH       = 2 * DELAY_LINES + 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic sig_o,
  output logic ovf_o
);
  localparam int DELAY = LINE_LEN * DELAY_LINES + DELAY_PIX;
  localparam int W     = edly_pkg::stamp_width(DELAY);
  localparam int LW    = $clog2(DEPTH + 1);
  localparam logic [W-1:0] DLY = W'(DELAY);

  logic          in_edge, push, pop, fifo_empty, fifo_full;
  logic [W-1:0]  stamp, head_stamp, age;
  logic [LW-1:0] fifo_level;

  edly_edge_det u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  (sig_i),
    .edge_o (in_edge)
  );

  edly_stamp_ctr #(.W(W)) u_ctr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .stamp_o (stamp)
  );

  edly_stamp_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .data_i  (stamp),
    .pop_i   (pop),
    .head_o  (head_stamp),
    .empty_o (fifo_empty),
    .full_o  (fifo_full),
    .level_o (fifo_level)
  );

  // modular age of the oldest pending edge
  assign age  = stamp - head_stamp;
  assign pop  = !fifo_empty && (age == DLY);
  assign push = in_edge && (!fifo_full || pop);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sig_o <= 1'b0;
      ovf_o <= 1'b0;
    end else begin
      if (pop) sig_o <= ~sig_o;
      if (in_edge && fifo_full && !pop) ovf_o <= 1'b1;
    end
  end
endmodule

// File: rtl/edge_delay_chk.sv
module edge_delay_chk #(
  parameter int DEPTH = 52,
  parameter int LW    = 6
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          sig_o,
  input logic          ovf_o,
  input logic [LW-1:0] level_i
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_quiet_r1: assert (sig_o == 1'b0 && ovf_o == 1'b0);
    end
  end

  p_level_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_i <= LW'(DEPTH));

  p_ovf_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o);

  p_ovf_cause_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_o) |-> $past(level_i) == LW'(DEPTH));

  p_toggle_pending_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sig_o != $past(sig_o)) |-> ($past(level_i) != '0));

  p_idle_steady_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_i == '0) |=> $stable(sig_o));
endmodule

bind edge_delay_line edge_delay_chk #(.DEPTH(DEPTH), .LW(LW)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .sig_o   (sig_o),
  .ovf_o   (ovf_o),
  .level_i (fifo_level)
);

// File: tb/edge_delay_line_tb_top.sv
module edge_delay_line_tb_top;
  localparam int LINE  = 64;
  localparam int LINES = 22;
  localparam int PIX   = 11;
  localparam int DEPTH = 52;
  localparam int D     = LINE * LINES + PIX;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sig_i = 1'b0;
  logic sig_o, ovf_o;

  int   n_chk = 0;
  int   n_bad = 0;
  bit   cmp_en = 1'b1;
  bit   done = 1'b0;
  string req = "R1";
  bit   exp_q[$];

  always #10 clk = ~clk;

  edge_delay_line #(
    .LINE_LEN(LINE), .DELAY_LINES(LINES), .DELAY_PIX(PIX), .DEPTH(DEPTH)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sig_i(sig_i), .sig_o(sig_o), .ovf_o(ovf_o)
  );

  task automatic check(input string r, input logic act, input logic exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", r, what, act, exp, $time);
    end
  endtask

  // driver: one value per cycle, pushed to the scoreboard
  task automatic drive(input bit v, input int n);
    for (int i = 0; i < n; i++) begin
      sig_i = v;
      exp_q.push_back(v);
      @(negedge clk);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    sig_i = 1'b0;
    exp_q.delete();
    for (int i = 0; i < D; i++) exp_q.push_back(1'b0);
    repeat (2) @(negedge clk);
    check("R1", sig_o, 1'b0, "sig_o in reset");
    check("R1", ovf_o, 1'b0, "ovf_o in reset");
    rst_n = 1'b1;
  endtask

  // monitor: pops the value sampled DELAY edges ago
  always @(posedge clk) begin
    #5;
    if (rst_n && exp_q.size() > D) begin
      bit e;
      e = exp_q.pop_front();
      if (cmp_en) begin
        check(req, sig_o, e, "sig_o");
        check(req, ovf_o, 1'b0, "ovf_o");
      end
    end
  end

  initial begin
    do_reset();
    req = "R1"; drive(1'b0, 20);
    req = "R9"; drive(1'b0, 100);
    req = "R2"; drive(1'b1, D + 200);
    req = "R3"; drive(1'b0, D + 200);
    req = "R4";
    for (int l = 0; l < 60; l++) begin
      drive(1'b1, 40);
      drive(1'b0, LINE - 40);
    end
    req = "R5";
    for (int p = 0; p < 10; p++) begin
      drive(1'b1, 1);
      drive(1'b0, 149);
    end
    req = "R7"; drive(1'b0, D + 50);
    for (int l = 0; l < 30; l++) begin
      drive(1'b1, 17);
      drive(1'b0, LINE - 17);
    end
    drive(1'b0, D + 50);

    // reset in the middle of a busy window
    req = "R8";
    for (int l = 0; l < 10; l++) begin
      drive(1'b1, 30);
      drive(1'b0, LINE - 30);
    end
    do_reset();
    drive(1'b0, D + 100);

    // queue filled to depth, then one edge more
    do_reset();
    cmp_en = 1'b0;
    for (int i = 0; i < DEPTH; i++) drive(i[0] ? 1'b0 : 1'b1, 1);
    check("R6", ovf_o, 1'b0, "ovf_o at depth");
    drive(DEPTH % 2 == 0 ? 1'b1 : 1'b0, 1);
    check("R6", ovf_o, 1'b1, "ovf_o past depth");
    drive(1'b0, 30);
    check("R6", ovf_o, 1'b1, "ovf_o sticky");
    do_reset();
    check("R6", ovf_o, 1'b0, "ovf_o cleared by reset");
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule